// File: doc/BRIEF.md
# Receive FIFO with Request-to-Send Flow Control

This block stores characters delivered by a serial receiver in a small first-in first-out queue. Each character carries three status flags: framing error, parity error and break detected. The host reads the oldest character and its flags from the head of the queue. A read strobe pops one entry. When the queue is empty, the head data output keeps showing the character that was popped last.

The block also drives an active-low request-to-send line for hardware flow control. Normally the line follows a host control bit. When automatic flow control is enabled, the line is forced inactive if the receiver reports a new start bit while every queue slot is occupied. The host bit itself is not altered. The line returns to the host-controlled level as soon as a slot frees up.

A character that arrives while the queue is full, with no read in the same cycle, is discarded and a sticky overrun flag is raised. The status outputs work in one of two modes. In per-character mode they show the flags of the head entry. In accumulated mode they show the OR of the flags of every character that has sat at the head since the last error-clear command.

Top module: `rxq_flow_top`

## Requirements
- R1: After reset the queue is empty, `rd_data` is 0, `overrun` is 0, all status outputs are 0, and `rts_n` equals the inverse of `rts_ctl`.
- R2: Characters written with `wr_en` are presented on `rd_data` in arrival order. `rx_avail` is 1 while at least one entry is held. `rx_full` is 1 when DEPTH entries are held. Every output reflects a clock edge's strobes in the cycle that follows it.
- R3: A `rd_en` on an empty queue changes nothing. `rd_data` then keeps showing the most recently popped character, or 0 if none has been popped yet.
- R4: A write while full, with no read in the same cycle, is dropped. The stored entries stay unchanged. `overrun` is set on the next cycle and stays set until `err_clr`; setting wins over clearing in the same cycle.
- R5: A write and a read in the same cycle on a full queue are both accepted, and the queue stays full.
- R6: With `block_mode`=0, `st_fe`, `st_pe` and `st_brk` show the flags of the head entry, and are 0 while the queue is empty.
- R7: With `block_mode`=1, each status output is the OR of that flag over every cycle since the last `err_clr` cycle (excluding it) in which a character sat at the head, including the current head.
- R8: With no automatic negation active, `rts_n` is the inverse of `rts_ctl`.
- R9: When `flow_en`=1 and `start_det`=1 while full with no read that cycle, `rts_n` is 1 from the next cycle while the queue remains full and `flow_en` stays 1. Once the queue is no longer full, `rts_n` returns to the inverse of `rts_ctl` with no host action.
- R10: `start_det` has no effect on `rts_n` when `flow_en`=0, when the queue is not full, or when a read occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Received character strobe |
| wr_data | input | DW | Received character |
| wr_fe | input | 1 | Framing error flag of the incoming character |
| wr_pe | input | 1 | Parity error flag of the incoming character |
| wr_brk | input | 1 | Break flag of the incoming character |
| start_det | input | 1 | Start bit detected strobe from the receiver |
| rd_en | input | 1 | Host read strobe; pops the head entry |
| flow_en | input | 1 | Enables automatic request-to-send negation |
| block_mode | input | 1 | 0: per-character status, 1: accumulated status |
| err_clr | input | 1 | Error-clear command; clears overrun and the accumulated status |
| rts_ctl | input | 1 | Host request-to-send control bit (1 = assert) |
| rd_data | output | DW | Head character, or the last popped character when empty |
| rx_avail | output | 1 | Queue holds at least one entry |
| rx_full | output | 1 | Queue holds DEPTH entries |
| st_fe | output | 1 | Framing error status |
| st_pe | output | 1 | Parity error status |
| st_brk | output | 1 | Break status |
| overrun | output | 1 | Sticky dropped-character flag |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The assertions assume the block leaves reset before any strobe is applied. They also assume every input holds a defined 0 or 1 at each rising edge, because pointer stability and the monotonic accumulator are judged from sampled strobes. The bench meets this by driving every input, from the start of reset onward, only on falling edges and only with defined values. Mode inputs change only between cycles, and the single-cycle strobes are drawn independently. This makes the corner combinations reachable: a write together with a read at full, and a start bit together with a read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int NFLAG  = 3;
   localparam int FL_FE  = 0;
   localparam int FL_PE  = 1;
   localparam int FL_BRK = 2;
   typedef logic [NFLAG-1:0] rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [DW-1:0] din_i,
   input  rxq_flags_t    fin_i,
   output logic [DW-1:0] head_data_o,
   output rxq_flags_t    head_flags_o,
   output logic          empty_o,
   output logic          full_o,
   output logic          pop_ok_o,
   output logic          drop_o
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0] data_mem [DEPTH];
   rxq_flags_t    flag_mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] last_q;
   logic          push_ok;

   assign empty_o  = (cnt_q == '0);
   assign full_o   = (cnt_q == CW'(DEPTH));
   assign pop_ok_o = pop_i & ~empty_o;
   assign push_ok  = push_i & (~full_o | pop_ok_o);
   assign drop_o   = push_i & full_o & ~pop_ok_o;

   generate
      if (POW2) begin : g_wrap_free
         assign rd_nxt = rd_q + 1'b1;
         assign wr_nxt = wr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         wr_q   <= '0;
         cnt_q  <= '0;
         last_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_nxt;
         if (pop_ok_o) begin
            rd_q   <= rd_nxt;
            last_q <= data_mem[rd_q];
         end
         case ({push_ok, pop_ok_o})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         data_mem[wr_q] <= din_i;
         flag_mem[wr_q] <= fin_i;
      end
   end

   assign head_data_o  = empty_o ? last_q : data_mem[rd_q];
   assign head_flags_o = empty_o ? '0 : flag_mem[rd_q];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_q) && $stable(rd_q))); // R4
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_q) && $stable(last_q))); // R3
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && pop_i) |=> full_o); // R5
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
   import rxq_pkg::*;
#(
   parameter bit HAS_BLOCK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       block_i,
   input  logic       clr_i,
   input  logic       empty_i,
   input  rxq_flags_t head_i,
   output rxq_flags_t stat_o
);
   generate
      if (HAS_BLOCK) begin : g_accum
         rxq_flags_t acc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     acc_q <= '0;
            else if (clr_i) acc_q <= '0;
            else            acc_q <= acc_q | head_i;
         end
         assign stat_o = block_i ? (acc_q | head_i) : head_i;

         AST_BLK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_i |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R7
      end else begin : g_char_only
         assign stat_o = head_i;
      end
   endgenerate

   AST_CHR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!block_i && empty_i) |-> (stat_o == '0)); // R6
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
   input  logic clk,
   input  logic rst_n,
   input  logic flow_en_i,
   input  logic start_i,
   input  logic full_i,
   input  logic pop_ok_i,
   input  logic host_i,
   output logic rts_n_o
);
   logic neg_q;
   logic neg_set;

   assign neg_set = flow_en_i & start_i & full_i & ~pop_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        neg_q <= 1'b0;
      else if (neg_set)  neg_q <= 1'b1;
      else if (!full_i)  neg_q <= 1'b0;
   end

   assign rts_n_o = ~host_i | (flow_en_i & neg_q & full_i);

   AST_RTS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      neg_set |=> neg_q); // R9
   AST_RTS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (neg_q && !full_i) |=> !neg_q); // R9
   AST_RTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_en_i && start_i && !neg_q) |=> !neg_q); // R10
endmodule

// File: rtl/rxq_flow_top.sv
module rxq_flow_top
   import rxq_pkg::*;
#(
   parameter int DW        = 8,
   parameter int DEPTH     = 8,
   parameter bit HAS_BLOCK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_fe,
   input  logic          wr_pe,
   input  logic          wr_brk,
   input  logic          start_det,
   input  logic          rd_en,
   input  logic          flow_en,
   input  logic          block_mode,
   input  logic          err_clr,
   input  logic          rts_ctl,
   output logic [DW-1:0] rd_data,
   output logic          rx_avail,
   output logic          rx_full,
   output logic          st_fe,
   output logic          st_pe,
   output logic          st_brk,
   output logic          overrun,
   output logic          rts_n
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_flow_top: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("rxq_flow_top: DW must be at least 1");
      end
   endgenerate

   rxq_flags_t in_flags, head_flags, stat;
   logic       empty, full, pop_ok, drop;
   logic       ovr_q;

   always_comb begin
      in_flags         = '0;
      in_flags[FL_FE]  = wr_fe;
      in_flags[FL_PE]  = wr_pe;
      in_flags[FL_BRK] = wr_brk;
   end

   rxq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (wr_en),
      .pop_i        (rd_en),
      .din_i        (wr_data),
      .fin_i        (in_flags),
      .head_data_o  (rd_data),
      .head_flags_o (head_flags),
      .empty_o      (empty),
      .full_o       (full),
      .pop_ok_o     (pop_ok),
      .drop_o       (drop)
   );

   rxq_errstat #(.HAS_BLOCK(HAS_BLOCK)) errstat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .block_i (block_mode),
      .clr_i   (err_clr),
      .empty_i (empty),
      .head_i  (head_flags),
      .stat_o  (stat)
   );

   rxq_rts rts_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flow_en_i (flow_en),
      .start_i   (start_det),
      .full_i    (full),
      .pop_ok_i  (pop_ok),
      .host_i    (rts_ctl),
      .rts_n_o   (rts_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (drop)    ovr_q <= 1'b1;
      else if (err_clr) ovr_q <= 1'b0;
   end

   assign overrun  = ovr_q;
   assign rx_avail = ~empty;
   assign rx_full  = full;
   assign st_fe    = stat[FL_FE];
   assign st_pe    = stat[FL_PE];
   assign st_brk   = stat[FL_BRK];

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !err_clr) |=> overrun); // R4
   AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rx_full && !rd_en) |=> overrun); // R4
endmodule

// File: tb/rxq_flow_top_tb.sv
module rxq_flow_top_tb_top;
   localparam int DW    = 8;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_wr = 0, i_rd = 0, i_start = 0, i_flow = 0, i_blk = 0, i_clr = 0, i_ctl = 0;
   logic [DW-1:0] i_data = '0;
   logic [2:0]    i_flags = '0;   // {brk, pe, fe}

   logic [DW-1:0] rd_data;
   logic rx_avail, rx_full, st_fe, st_pe, st_brk, overrun, rts_n;

   always #2 clk = ~clk;

   rxq_flow_top #(.DW(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(i_wr), .wr_data(i_data),
      .wr_fe(i_flags[0]), .wr_pe(i_flags[1]), .wr_brk(i_flags[2]),
      .start_det(i_start), .rd_en(i_rd), .flow_en(i_flow), .block_mode(i_blk),
      .err_clr(i_clr), .rts_ctl(i_ctl), .rd_data(rd_data), .rx_avail(rx_avail),
      .rx_full(rx_full), .st_fe(st_fe), .st_pe(st_pe), .st_brk(st_brk),
      .overrun(overrun), .rts_n(rts_n)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // behavioural reference state
   logic [DW+2:0] mq[$];
   logic [DW-1:0] m_last = '0;
   logic [2:0]    m_acc  = '0;
   bit            m_ovr  = 0;
   bit            m_neg  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic mdl_update();
      int         sz    = mq.size();
      bit         mfull = (sz == DEPTH);
      bit         mempt = (sz == 0);
      bit         pop   = i_rd && !mempt;
      bit         push  = i_wr && (!mfull || pop);
      logic [2:0] hf    = mempt ? 3'b000 : mq[0][2:0];
      m_acc = i_clr ? 3'b000 : (m_acc | hf);
      if (i_wr && mfull && !pop) m_ovr = 1;
      else if (i_clr)            m_ovr = 0;
      if (i_flow && i_start && mfull && !pop) m_neg = 1;
      else if (!mfull)                        m_neg = 0;
      if (pop) begin
         m_last = mq[0][DW+2:3];
         void'(mq.pop_front());
      end
      if (push) mq.push_back({i_data, i_flags});
   endtask

   task automatic compare_all();
      bit         mempt = (mq.size() == 0);
      bit         mfull = (mq.size() == DEPTH);
      logic [2:0] hf    = mempt ? 3'b000 : mq[0][2:0];
      logic [2:0] ef    = i_blk ? (m_acc | hf) : hf;
      bit         auto  = i_flow && m_neg && mfull;
      chk(mempt ? "R3 rd_data" : "R2 rd_data", 32'(rd_data), mempt ? 32'(m_last) : 32'(mq[0][DW+2:3]));
      chk("R2 rx_avail", 32'(rx_avail), 32'(!mempt));
      chk("R2 rx_full", 32'(rx_full), 32'(mfull));
      chk(i_blk ? "R7 status" : "R6 status", 32'({st_brk, st_pe, st_fe}), 32'(ef));
      chk("R4 overrun", 32'(overrun), 32'(m_ovr));
      chk(auto ? "R9 rts_n" : "R8 rts_n", 32'(rts_n), 32'(!i_ctl || auto));
   endtask

   task automatic step(input bit w, input logic [DW-1:0] d, input logic [2:0] f,
                       input bit r, input bit s, input bit c);
      i_wr = w; i_data = d; i_flags = f; i_rd = r; i_start = s; i_clr = c;
      @(posedge clk);
      mdl_update();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      i_ctl = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk("R1 rx_avail", 32'(rx_avail), 32'd0);
      chk("R1 rd_data", 32'(rd_data), 32'd0);
      chk("R1 overrun", 32'(overrun), 32'd0);
      chk("R1 status", 32'({st_brk, st_pe, st_fe}), 32'd0);
      chk("R1 rts_n", 32'(rts_n), 32'd0);

      // R3: read on empty after reset
      step(0, 8'h00, 3'b000, 1, 0, 0);
      chk("R3 empty read data", 32'(rd_data), 32'd0);

      // R2 fill in order with mixed flags (char mode, R6)
      i_flow = 1;
      for (int k = 0; k < DEPTH; k++) step(1, 8'h10 + 8'(k), 3'(k), 0, 0, 0);
      chk("R2 full after fill", 32'(rx_full), 32'd1);
      chk("R6 head flags", 32'({st_brk, st_pe, st_fe}), 32'd0);

      // R9 start bit while full
      step(0, 8'h00, 3'b000, 0, 1, 0);
      chk("R9 rts negated", 32'(rts_n), 32'd1);

      // R4 drop while full, contents kept
      step(1, 8'h99, 3'b111, 0, 0, 0);
      chk("R4 overrun set", 32'(overrun), 32'd1);
      chk("R4 head kept", 32'(rd_data), 32'h10);

      // R9 release on a read
      step(0, 8'h00, 3'b000, 1, 0, 0);
      chk("R9 rts released", 32'(rts_n), 32'd0);
      chk("R4 overrun held", 32'(overrun), 32'd1);
      step(1, 8'h20, 3'b001, 0, 0, 0);

      // R10: start ignored with flow disabled, and with a read the same cycle
      i_flow = 0;
      step(0, 8'h00, 3'b000, 0, 1, 0);
      chk("R10 flow off", 32'(rts_n), 32'd0);
      i_flow = 1;
      step(1, 8'h21, 3'b000, 1, 1, 0);
      chk("R10 start with read", 32'(rts_n), 32'd0);

      // R5 write and read together at full
      chk("R5 full before", 32'(rx_full), 32'd1);
      step(1, 8'h22, 3'b010, 1, 0, 0);
      chk("R5 still full", 32'(rx_full), 32'd1);

      // R4 clear
      step(0, 8'h00, 3'b000, 0, 0, 1);
      chk("R4 overrun cleared", 32'(overrun), 32'd0);

      // R3 drain and over-read
      for (int k = 0; k < DEPTH; k++) step(0, 8'h00, 3'b000, 1, 0, 0);
      step(0, 8'h00, 3'b000, 1, 0, 0);
      chk("R3 last data kept", 32'(rd_data), 32'h22);
      chk("R3 empty", 32'(rx_avail), 32'd0);

      // R7 block mode accumulation
      step(0, 8'h00, 3'b000, 0, 0, 1);
      i_blk = 1;
      step(1, 8'h31, 3'b001, 0, 0, 0);
      step(1, 8'h32, 3'b100, 0, 0, 0);
      step(0, 8'h00, 3'b000, 1, 0, 0);
      step(0, 8'h00, 3'b000, 1, 0, 0);
      chk("R7 accumulated", 32'({st_brk, st_pe, st_fe}), 32'b101);
      step(0, 8'h00, 3'b000, 0, 0, 1);
      chk("R7 cleared", 32'({st_brk, st_pe, st_fe}), 32'b000);
      i_blk = 0;

      // R8 host control
      i_ctl = 0;
      step(0, 8'h00, 3'b000, 0, 0, 0);
      chk("R8 host negate", 32'(rts_n), 32'd1);
      i_ctl = 1;

      // random mix, compared every cycle
      for (int n = 0; n < 6000; n++) begin
         if ((n % 700) == 0) i_blk = ~i_blk;
         i_flow = ($urandom_range(0, 9) != 0);
         i_ctl  = ($urandom_range(0, 15) != 0);
         step($urandom_range(0, 9) < 5, 8'($urandom), 3'($urandom),
              $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 3,
              $urandom_range(0, 29) == 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule